// File: doc/BRIEF.md
# DMA Control Port Decoder and Channel Arbiter

This block is the control-register half of a four-channel DMA controller. A host writes single bytes to eight control ports to set the command byte, raise or drop software requests, mask channels one at a time or all at once, store a per-channel mode byte, clear the byte pointer used by the channel registers, or apply a master reset. It can read back two of those ports: the status byte and the mask byte. The port is picked by bits [SHIFT+3:SHIFT] of the address. SHIFT is 0 for a controller with byte-spaced ports and 1 for one with word-spaced ports.

The status byte has two nibbles. The upper nibble holds the per-channel request flags. Software sets and clears them through the request port, and peripherals set and clear them through the hold and release inputs. The lower nibble holds the per-channel terminal-count flags, which the data-movement logic sets by pulsing `tc_i`. A status read clears the lower nibble and keeps the upper one.

From the mask and the request flags the block drives a one-hot grant each cycle. The grant goes to the lowest-numbered channel that is unmasked and requesting. Moving data is left to the neighbouring logic.

Top module: `dma_ctl_top`

## Requirements
- R1: Synchronous reset sets the mask byte to 0xFF. It clears the status byte, the command byte, the byte pointer and all mode bytes, and `grant_o` reads 0.
- R2: A write to port 0 loads the command byte only when the value is 0x00 or 0x04. Any other value leaves the command byte unchanged.
- R3: A write to port 1 uses data bits [1:0] as the channel. It sets (data bit 2 = 1) or clears (bit 2 = 0) status bit channel+4, and it always clears status bit channel.
- R4: A write to port 2 sets or clears mask bit data[1:0] according to data bit 2. A write to port 6 clears the whole mask byte, and a write to port 7 loads it with the data byte.
- R5: A write to port 3 stores the full data byte as the mode of channel data[1:0], shown on `mode_o[8*ch+7:8*ch]`. Bit 5 of that mode appears on `dir_o[ch]`.
- R6: The byte pointer `ptr_o` toggles on each `ptr_flip_i` cycle and is cleared by a write to port 4.
- R7: A write to port 5 clears the pointer, the status byte and the command byte, and sets the mask byte to 0xFF. Mode bytes are left unchanged.
- R8: A read of port 0 returns the status byte in the same cycle. On the next edge status bits [3:0] are cleared and bits [7:4] are kept.
- R9: A read of port 1 returns the mask byte. A read of any other port returns 0. Writes to ports 8 to 15 change nothing.
- R10: `grant_o` is one-hot or zero. It selects the lowest-numbered channel whose mask bit is 0 and whose status bit channel+4 is 1.
- R11: A 1 on `hold_i[ch]` sets status bit ch+4, and a 1 on `release_i[ch]` clears it. Release wins when both are set.
- R12: Address bits below SHIFT do not affect the decoded port.
- R13: A 1 on `tc_i[ch]` sets status bit ch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Port write strobe |
| rd_en | input | 1 | Port read strobe |
| addr | input | SHIFT+4 | Port address; bits [SHIFT+3:SHIFT] pick the port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| hold_i | input | 4 | Per-channel external request set |
| release_i | input | 4 | Per-channel external request clear |
| tc_i | input | 4 | Per-channel terminal-count pulse |
| ptr_flip_i | input | 1 | Toggle the byte pointer |
| grant_o | output | 4 | One-hot grant to the serviced channel |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 32 | Mode bytes, channel 0 in the low byte |
| dir_o | output | 4 | Address-decrement bit of each mode byte |
| ptr_o | output | 1 | Byte pointer |

## Verification
The status-read assertion assumes that no request write, master reset, hold, release or terminal-count pulse lands in the same cycle as the read. Only under that condition is the upper nibble required to stay as it was. The bench keeps to this by driving one stimulus per cycle. Each host access lasts exactly one clock, so each write or read clears or sets flags only once. The bench uses SHIFT = 1 and drives some accesses with the low address bit set, so that the address shift is checked as well.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
    localparam int NCH  = 4;
    localparam int DW   = 8;
    localparam int CHW  = $clog2(NCH);
    localparam int NPORT = 8;

    typedef enum logic [3:0] {
        PORT_CMD     = 4'd0,
        PORT_REQ     = 4'd1,
        PORT_SMASK   = 4'd2,
        PORT_MODE    = 4'd3,
        PORT_CLRPTR  = 4'd4,
        PORT_MRESET  = 4'd5,
        PORT_CLRMASK = 4'd6,
        PORT_WRMASK  = 4'd7
    } port_e;

    typedef struct packed {
        logic [NCH-1:0] req;
        logic [NCH-1:0] tc;
    } status_t;

    localparam logic [DW-1:0] CMD_ALLOWED = 8'h04;

    function automatic logic cmd_ok(input logic [DW-1:0] v);
        return (v & ~CMD_ALLOWED) == '0;
    endfunction
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
    import dma_ctl_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int AW = SHIFT + 4
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [NPORT-1:0]  wr_sel,
    output logic              rd_status,
    output logic              rd_mask,
    output logic [CHW-1:0]    ch,
    output logic              set_bit
);
    logic [3:0] idx;
    logic [AW-1:0] shifted;
    logic unused_wdata;

    assign shifted = addr >> SHIFT;
    assign idx     = shifted[3:0];
    assign ch      = wdata[CHW-1:0];
    assign set_bit = wdata[2];
    assign unused_wdata = ^wdata[DW-1:3];

    for (genvar p = 0; p < NPORT; p++) begin : g_sel
        assign wr_sel[p] = wr_en && (idx == 4'(p));
    end

    assign rd_status = rd_en && (port_e'(idx) == PORT_CMD);
    assign rd_mask   = rd_en && (port_e'(idx) == PORT_REQ);
endmodule

// File: rtl/dma_ctl_cfg.sv
module dma_ctl_cfg
    import dma_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORT-1:0]  wr_sel,
    input  logic [DW-1:0]     wdata,
    input  logic [CHW-1:0]    ch,
    input  logic              set_bit,
    input  logic              ptr_flip,
    output logic [DW-1:0]     cmd_q,
    output logic [DW-1:0]     mask_q,
    output logic [NCH*DW-1:0] mode_q,
    output logic              ptr_q
);
    logic [DW-1:0] mode_r [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            mask_q <= '1;
            ptr_q  <= 1'b0;
        end else begin
            if (wr_sel[PORT_CMD] && cmd_ok(wdata))
                cmd_q <= wdata;
            if (wr_sel[PORT_SMASK])
                mask_q[{1'b0, ch}] <= set_bit;
            if (wr_sel[PORT_CLRMASK])
                mask_q <= '0;
            if (wr_sel[PORT_WRMASK])
                mask_q <= wdata;
            if (wr_sel[PORT_CLRPTR])
                ptr_q <= 1'b0;
            else if (ptr_flip)
                ptr_q <= ~ptr_q;
            if (wr_sel[PORT_MRESET]) begin
                cmd_q  <= '0;
                mask_q <= '1;
                ptr_q  <= 1'b0;
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst)
                mode_r[c] <= '0;
            else if (wr_sel[PORT_MODE] && ch == CHW'(c))
                mode_r[c] <= wdata;
        end
        assign mode_q[c*DW +: DW] = mode_r[c];
    end

    // R2: rejected command values leave the command byte alone
    a_r2_cmd_reject: assert property (@(posedge clk) disable iff (rst)
        (wr_sel[PORT_CMD] && wdata != 8'h00 && wdata != 8'h04) |=> $stable(cmd_q));

    // R7: master reset outcome
    a_r7_master_reset: assert property (@(posedge clk) disable iff (rst)
        wr_sel[PORT_MRESET] |=> (mask_q == 8'hFF && cmd_q == 8'h00 && !ptr_q));

    // R6: pointer clear
    a_r6_ptr_clear: assert property (@(posedge clk) disable iff (rst)
        wr_sel[PORT_CLRPTR] |=> !ptr_q);
endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status
    import dma_ctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_req,
    input  logic           wr_mreset,
    input  logic           rd_status,
    input  logic [CHW-1:0] ch,
    input  logic           set_bit,
    input  logic [NCH-1:0] hold_i,
    input  logic [NCH-1:0] release_i,
    input  logic [NCH-1:0] tc_i,
    output status_t        status_q
);
    status_t nxt;

    always_comb begin
        nxt = status_q;
        if (rd_status)
            nxt.tc = '0;
        if (wr_req) begin
            nxt.req[ch] = set_bit;
            nxt.tc[ch]  = 1'b0;
        end
        if (wr_mreset)
            nxt = '0;
        nxt.req = (nxt.req | hold_i) & ~release_i;
        nxt.tc  = nxt.tc | tc_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else
            status_q <= nxt;
    end

    // R8: a quiet status read drops the low nibble and keeps the high one
    a_r8_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !wr_req && !wr_mreset && hold_i == '0 && release_i == '0 && tc_i == '0)
        |=> (status_q.tc == '0 && status_q.req == $past(status_q.req)));

    // R11: release always leaves its request flag clear
    a_r11_release: assert property (@(posedge clk) disable iff (rst)
        (release_i != '0) |=> ((status_q.req & $past(release_i)) == '0));

    // R13: terminal count always lands
    a_r13_tc_set: assert property (@(posedge clk) disable iff (rst)
        (tc_i != '0) |=> ((status_q.tc & $past(tc_i)) == $past(tc_i)));
endmodule

// File: rtl/dma_ctl_arb.sv
module dma_ctl_arb
    import dma_ctl_pkg::*;
(
    input  logic [NCH-1:0] masked,
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] grant
);
    logic [NCH-1:0] elig;
    logic [NCH:0]   taken;

    assign elig     = req & ~masked;
    assign taken[0] = 1'b0;

    for (genvar c = 0; c < NCH; c++) begin : g_pri
        assign grant[c]   = elig[c] & ~taken[c];
        assign taken[c+1] = taken[c] | elig[c];
    end
endmodule

// File: rtl/dma_ctl_top.sv
module dma_ctl_top
    import dma_ctl_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int AW = SHIFT + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [3:0]        hold_i,
    input  logic [3:0]        release_i,
    input  logic [3:0]        tc_i,
    input  logic              ptr_flip_i,
    output logic [3:0]        grant_o,
    output logic [7:0]        cmd_o,
    output logic [31:0]       mode_o,
    output logic [3:0]        dir_o,
    output logic              ptr_o
);
    logic [NPORT-1:0] wr_sel;
    logic             rd_status, rd_mask, set_bit;
    logic [CHW-1:0]   ch;
    logic [DW-1:0]    mask_q;
    status_t          status_q;

    dma_ctl_decode #(.SHIFT(SHIFT)) u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .wr_sel(wr_sel), .rd_status(rd_status), .rd_mask(rd_mask),
        .ch(ch), .set_bit(set_bit)
    );

    dma_ctl_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(wdata), .ch(ch),
        .set_bit(set_bit), .ptr_flip(ptr_flip_i), .cmd_q(cmd_o),
        .mask_q(mask_q), .mode_q(mode_o), .ptr_q(ptr_o)
    );

    dma_ctl_status u_stat (
        .clk(clk), .rst(rst), .wr_req(wr_sel[PORT_REQ]),
        .wr_mreset(wr_sel[PORT_MRESET]), .rd_status(rd_status), .ch(ch),
        .set_bit(set_bit), .hold_i(hold_i), .release_i(release_i),
        .tc_i(tc_i), .status_q(status_q)
    );

    dma_ctl_arb u_arb (
        .masked(mask_q[NCH-1:0]), .req(status_q.req), .grant(grant_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_dir
        assign dir_o[c] = mode_o[c*DW + 5];
    end

    always_comb begin
        rdata = '0;
        if (rd_status)
            rdata = status_q;
        else if (rd_mask)
            rdata = mask_q;
    end

    // R10: grant is one-hot and points at an eligible channel
    a_r10_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));
    a_r10_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        (grant_o != '0) |-> ((grant_o & mask_q[3:0]) == '0 && (grant_o & status_q.req) == grant_o));
    a_r10_grant_live: assert property (@(posedge clk) disable iff (rst)
        ((status_q.req & ~mask_q[3:0]) != '0) |-> (grant_o != '0));
endmodule

// File: tb/tb_dma_ctl_top.sv
module tb_dma_ctl_top;
    localparam int SH = 1;

    logic        clk = 0, rst = 1, wr_en = 0, rd_en = 0, ptr_flip_i = 0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0, rdata, cmd_o;
    logic [3:0]  hold_i = '0, release_i = '0, tc_i = '0, grant_o, dir_o;
    logic [31:0] mode_o;
    logic        ptr_o;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    dma_ctl_top #(.SHIFT(SH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hold_i(hold_i), .release_i(release_i),
        .tc_i(tc_i), .ptr_flip_i(ptr_flip_i), .grant_o(grant_o), .cmd_o(cmd_o),
        .mode_o(mode_o), .dir_o(dir_o), .ptr_o(ptr_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int port, input logic [7:0] d, input bit lsb = 0);
        @(negedge clk);
        addr = 5'((port << SH) | int'(lsb)); wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int port, output logic [7:0] v);
        @(negedge clk);
        addr = 5'(port << SH); rd_en = 1;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic pulse(input logic [3:0] h, input logic [3:0] r, input logic [3:0] t, input bit f);
        @(negedge clk);
        hold_i = h; release_i = r; tc_i = t; ptr_flip_i = f;
        @(negedge clk);
        hold_i = 0; release_i = 0; tc_i = 0; ptr_flip_i = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        rd(1, v); check("R1 mask", v, 8'hFF);
        rd(0, v); check("R1 status", v, 8'h00);
        check("R1 grant", grant_o, 0);
        check("R1 cmd", cmd_o, 0);
        check("R1 ptr", ptr_o, 0);
        check("R1 mode", mode_o, 0);
    endtask

    task automatic t_command;
        wr(0, 8'h04); check("R2 accept 04", cmd_o, 8'h04);
        wr(0, 8'h05); check("R2 reject 05", cmd_o, 8'h04);
        wr(0, 8'h80); check("R2 reject 80", cmd_o, 8'h04);
        wr(0, 8'h00); check("R2 accept 00", cmd_o, 8'h00);
        wr(0, 8'h10); check("R2 reject 10", cmd_o, 8'h00);
    endtask

    task automatic t_request;
        logic [7:0] v;
        wr(1, 8'h06); check("R3 masked no grant", grant_o, 0);
        wr(6, 8'h00); check("R4 clear-all grant", grant_o, 4'b0100);
        rd(0, v); check("R3 status set", v, 8'h40);
        wr(1, 8'h02); check("R3 cleared grant", grant_o, 0);
        pulse(0, 0, 4'b0100, 0);
        rd(0, v); check("R13 tc status", v, 8'h04);
        pulse(0, 0, 4'b0100, 0);
        wr(1, 8'h06); rd(0, v); check("R3 req clears tc bit", v, 8'h40);
        wr(1, 8'h02); rd(0, v); check("R3 status cleared", v, 8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] v;
        wr(1, 8'h05); check("R10 grant ch1", grant_o, 4'b0010);
        wr(2, 8'h05); check("R4 single mask set", grant_o, 0);
        rd(1, v); check("R9 mask read", v, 8'h02);
        wr(2, 8'h01); check("R4 single mask clr", grant_o, 4'b0010);
        wr(7, 8'hA5, 1); rd(1, v); check("R12 odd address load", v, 8'hA5);
        check("R4 write-all grant", grant_o, 4'b0010);
        wr(1, 8'h01); check("R3 drop ch1", grant_o, 0);
    endtask

    task automatic t_mode;
        wr(3, 8'hA3); check("R5 mode ch3", mode_o[31:24], 8'hA3);
        check("R5 dir", dir_o, 4'b1000);
        wr(3, 8'h10); check("R5 mode ch0", mode_o, 32'hA300_0010);
        check("R5 dir kept", dir_o, 4'b1000);
    endtask

    task automatic t_ptr;
        pulse(0, 0, 0, 1); check("R6 flip1", ptr_o, 1);
        pulse(0, 0, 0, 1); check("R6 flip2", ptr_o, 0);
        pulse(0, 0, 0, 1); wr(4, 8'h00); check("R6 clear", ptr_o, 0);
    endtask

    task automatic t_status_read;
        logic [7:0] v;
        pulse(4'b1000, 0, 0, 0);
        pulse(0, 0, 4'b0010, 0);
        rd(0, v); check("R8 first read", v, 8'h82);
        rd(0, v); check("R8 low cleared", v, 8'h80);
        pulse(0, 4'b1000, 0, 0);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        wr(6, 8'h00);
        pulse(4'b1010, 0, 0, 0); check("R10 lowest wins", grant_o, 4'b0010);
        rd(0, v); check("R11 hold sets", v, 8'hA0);
        wr(2, 8'h05); check("R10 next channel", grant_o, 4'b1000);
        pulse(0, 4'b1000, 0, 0); check("R11 release grant", grant_o, 0);
        rd(0, v); check("R11 release status", v, 8'h20);
        pulse(4'b0100, 4'b0110, 0, 0);
        rd(0, v); check("R11 release wins", v, 8'h00);
    endtask

    task automatic t_other;
        logic [7:0] v;
        rd(2, v); check("R9 port2 read", v, 0);
        rd(9, v); check("R9 port9 read", v, 0);
        wr(8, 8'hFF); wr(13, 8'h04);
        rd(1, v); check("R9 high port no mask", v, 8'h02);
        check("R9 high port no cmd", cmd_o, 0);
    endtask

    task automatic t_mreset;
        logic [7:0] v;
        wr(0, 8'h04); wr(6, 8'h00);
        pulse(4'b0001, 0, 4'b0001, 1);
        check("R7 pre grant", grant_o, 4'b0001);
        wr(5, 8'h00);
        rd(1, v); check("R7 mask", v, 8'hFF);
        rd(0, v); check("R7 status", v, 0);
        check("R7 cmd", cmd_o, 0);
        check("R7 ptr", ptr_o, 0);
        check("R7 grant", grant_o, 0);
        check("R7 modes kept", mode_o, 32'hA300_0010);
    endtask

    initial begin
        t_reset();
        t_command();
        t_request();
        t_mask();
        t_mode();
        t_ptr();
        t_status_read();
        t_hold();
        t_other();
        t_mreset();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule